// File: doc/BRIEF.md
# Byte-Lane Bus Access Sequencer

This block sits between a processor-side load/store port and a 16-bit external bus. The bus has two byte lanes and a 20-bit byte address. Each request is a read or a write of one byte or one 16-bit word, and it may target any byte address. The block turns each request into one or two bus cycles. For every cycle it drives the address, an active-low high-lane enable and write data already placed on the right lane.

The lane choice comes from the pair (high-lane enable, address bit 0). Words at even addresses move in a single full-width cycle. Words at odd addresses are split into two byte cycles. Read results are collected little-endian and returned right-justified. A ready input stretches every bus cycle. A one-cycle done pulse marks the end of the request, and only then is the sequencer free to accept the next one.

Top module: `lane_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bus_active_o`=0, `bus_bhe_no`=1, `done_o`=0 and `req_ready_o`=1.
- R2: A word request at an even address produces exactly one bus cycle at that address with `bus_bhe_no`=0, so both lanes are in use.
- R3: A byte request produces one bus cycle at its own address. At an even address `bus_bhe_no`=1, so only the lower lane D7..D0 is used. At an odd address `bus_bhe_no`=0, so only the upper lane D15..D8 is used. While a cycle is active, `bus_bhe_no`=1 together with `bus_addr_o[0]`=1 never appears.
- R4: A word request at an odd address A produces two bus cycles in this order: first at A with `bus_bhe_no`=0, then at (A+1) modulo 2^20 with `bus_bhe_no`=1.
- R5: On writes `bus_wr_o`=1, and on reads it is 0. An aligned word write drives the request data unchanged. A byte write drives {b,b}, where b is data[7:0]. A misaligned word write drives {lo,lo} in its first cycle and {hi,hi} in its second.
- R6: The byte at the lower address is the least significant byte. A byte read returns {8'h00, byte taken from the enabled lane}. A misaligned word read returns {lower lane of the second cycle, upper lane of the first cycle}. Data on a lane that is not enabled has no effect on the result.
- R7: While `bus_ready_i` is sampled low, the address, enable, write strobe and write data stay unchanged. Each low sample adds exactly one cycle to that bus cycle.
- R8: `done_o` is high for exactly one cycle, the cycle after the edge at which the last bus cycle saw `bus_ready_i`=1. `rdata_o` holds the read result from then until the next read completes. A write leaves `rdata_o` unchanged.
- R9: `req_ready_o` is 1 only while no bus cycle is active. A `req_valid_i` that arrives while the block is busy is ignored and starts no extra cycle.
- R10: An accepted request puts its first bus cycle on the outputs in the cycle right after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data, right-justified |
| req_ready_o | output | 1 | Sequencer idle, request accepted at this edge if valid |
| done_o | output | 1 | One-cycle pulse after the final bus cycle |
| rdata_o | output | 16 | Right-justified read result |
| bus_active_o | output | 1 | A bus cycle is in progress |
| bus_wr_o | output | 1 | Bus cycle direction, 1 = write |
| bus_addr_o | output | 20 | Bus byte address |
| bus_bhe_no | output | 1 | High-lane enable, active low |
| bus_wdata_o | output | 16 | Lane-steered write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_ready_i | input | 1 | Ends the current bus cycle when high |

## Verification
The first bus cycle is due one cycle after the accepting edge. Each bus cycle lasts one cycle plus one cycle for every low ready sample. The second half of a split word starts in the cycle after the first half completes. `done_o` and `rdata_o` are due one cycle after the final completing edge. The bench works out these positions from the request and its chosen wait counts, and it samples on falling edges at exactly those cycles: it checks every bus cycle on every one of its cycles, the done cycle, and the idle cycle after it. The sweep covers every request kind, both lane parities, wait counts from zero to two, and the wrap from the top address to zero.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_e;

  function automatic logic [DATA_W-1:0] lane_dup(input logic [LANE_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < int'(LANES); i++) r[i*LANE_W +: LANE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/lane_seq_ctl.sv
module lane_seq_ctl
  import lane_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              bus_ready_i,
  input  logic              two_cycle_i,
  output seq_state_e        state_o,
  output logic              write_o,
  output logic              word_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cyc_done_o,
  output logic              done_o
);
  seq_state_e st_q, st_d;
  logic accept, last_cyc;

  assign accept     = (st_q == SEQ_IDLE) && req_valid_i;
  assign cyc_done_o = (st_q != SEQ_IDLE) && bus_ready_i;
  assign last_cyc   = cyc_done_o && ((st_q == SEQ_SECOND) || !two_cycle_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:   if (accept) st_d = SEQ_FIRST;
      SEQ_FIRST:  if (cyc_done_o) st_d = two_cycle_i ? SEQ_SECOND : SEQ_IDLE;
      SEQ_SECOND: if (cyc_done_o) st_d = SEQ_IDLE;
      default:    st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_IDLE;
      write_o <= 1'b0;
      word_o  <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= last_cyc;
      if (accept) begin
        write_o <= req_write_i;
        word_o  <= req_word_i;
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
    end
  end

  assign state_o = st_q;

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_SECOND) |-> ($past(st_q) != SEQ_IDLE)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
endmodule

// File: rtl/lane_plan.sv
module lane_plan
  import lane_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              second_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              two_cycle_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic misal;
  assign misal       = word_i && addr_i[0];
  assign two_cycle_o = misal;
  // second half of a split word goes to the following even address
  assign addr_o      = second_i ? addr_i + ADDR_W'(1) : addr_i;

  always_comb begin
    if (word_i) bhe_n_o = misal && second_i;
    else        bhe_n_o = !addr_i[0];
  end

  always_comb begin
    if (word_i && !misal)  wdata_o = wdata_i;
    else if (misal && second_i) wdata_o = lane_dup(wdata_i[DATA_W-1 -: LANE_W]);
    else                   wdata_o = lane_dup(wdata_i[LANE_W-1:0]);
  end
endmodule

// File: rtl/lane_gather.sv
module lane_gather
  import lane_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_done_i,
  input  logic              second_i,
  input  logic              write_i,
  input  logic              word_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANE_W-1:0] lo_lane, hi_lane;
  assign lo_lane = bus_rdata_i[LANE_W-1:0];
  assign hi_lane = bus_rdata_i[DATA_W-1 -: LANE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (cyc_done_i && !write_i) begin
      if (word_i && !a0_i)       rdata_o <= bus_rdata_i;
      else if (word_i && !second_i) rdata_o[LANE_W-1:0] <= hi_lane;
      else if (word_i)           rdata_o[DATA_W-1 -: LANE_W] <= lo_lane;
      else                       rdata_o <= {{(DATA_W-LANE_W){1'b0}}, (a0_i ? hi_lane : lo_lane)};
    end
  end

  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_done_i && write_i) |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/lane_seq.sv
module lane_seq
  import lane_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [15:0]       rdata_o,
  output logic              bus_active_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_bhe_no,
  output logic [15:0]       bus_wdata_o,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_ready_i
);
  seq_state_e        st;
  logic              wr_q, word_q, cyc_done, two_cycle, second, p_bhe_n;
  logic [ADDR_W-1:0] addr_q, p_addr;
  logic [DATA_W-1:0] wdata_q, p_wdata;

  lane_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_word_i, .req_addr_i,
    .req_wdata_i, .bus_ready_i, .two_cycle_i(two_cycle), .state_o(st),
    .write_o(wr_q), .word_o(word_q), .addr_o(addr_q), .wdata_o(wdata_q),
    .cyc_done_o(cyc_done), .done_o
  );

  assign second = (st == SEQ_SECOND);

  lane_plan #(.ADDR_W(ADDR_W)) u_plan (
    .second_i(second), .word_i(word_q), .addr_i(addr_q), .wdata_i(wdata_q),
    .two_cycle_o(two_cycle), .addr_o(p_addr), .bhe_n_o(p_bhe_n), .wdata_o(p_wdata)
  );

  lane_gather u_gather (
    .clk_i, .rst_ni, .cyc_done_i(cyc_done), .second_i(second), .write_i(wr_q),
    .word_i(word_q), .a0_i(addr_q[0]), .bus_rdata_i, .rdata_o
  );

  assign bus_active_o = (st != SEQ_IDLE);
  assign req_ready_o  = !bus_active_o;
  assign bus_wr_o     = bus_active_o && wr_q;
  assign bus_addr_o   = bus_active_o ? p_addr : '0;
  assign bus_bhe_no   = bus_active_o ? p_bhe_n : 1'b1;
  assign bus_wdata_o  = bus_active_o ? p_wdata : '0;

  AST_NO_RESERVED_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_active_o |-> !(bus_bhe_no && bus_addr_o[0])); // R3
  AST_HOLD_ON_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_active_o && !bus_ready_i) |=> (bus_active_o && $stable(bus_addr_o) &&
      $stable(bus_bhe_no) && $stable(bus_wdata_o) && $stable(bus_wr_o))); // R7
  AST_SPLIT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_active_o && $past(bus_active_o) && $past(bus_ready_i)) |->
      (bus_addr_o == $past(bus_addr_o) + ADDR_W'(1) && bus_bhe_no && !$past(bus_bhe_no))); // R4
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_active_o && bus_ready_i)); // R8
  AST_START_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_active_o) |-> $past(req_valid_i && req_ready_o)); // R10
endmodule

// File: tb/lane_seq_bench.sv
module lane_seq_bench;
  localparam int AW = 20;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_rdata = '0;
  logic bus_ready = 0;
  logic req_ready, done, bus_active, bus_wr, bus_bhe_n;
  logic [15:0] rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] last_read = 16'h0000;

  always #10 clk = ~clk;

  lane_seq #(.ADDR_W(AW)) u_lane_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_word_i(req_word), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .done_o(done), .rdata_o(rdata), .bus_active_o(bus_active),
    .bus_wr_o(bus_wr), .bus_addr_o(bus_addr), .bus_bhe_no(bus_bhe_n),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready)
  );

  function automatic logic [7:0] mem_b(input logic [AW-1:0] x);
    return 8'((x * 37) ^ (x >> 9) ^ 20'h0005C);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input bit wd, input logic [AW-1:0] a, input logic [15:0] d, input int wbase);
    int n;
    logic [AW-1:0] ea [2];
    logic eb [2];
    logic [15:0] ed [2];
    logic [15:0] exp_r;
    if (wd && !a[0]) begin
      n = 1; ea[0] = a; eb[0] = 1'b0; ed[0] = d;
      exp_r = {mem_b((a + 1) & AMASK), mem_b(a)};
    end else if (wd) begin
      n = 2; ea[0] = a; eb[0] = 1'b0; ed[0] = {d[7:0], d[7:0]};
      ea[1] = (a + 1) & AMASK; eb[1] = 1'b1; ed[1] = {d[15:8], d[15:8]};
      exp_r = {mem_b((a + 1) & AMASK), mem_b(a)};
    end else begin
      n = 1; ea[0] = a; eb[0] = !a[0]; ed[0] = {d[7:0], d[7:0]};
      exp_r = {8'h00, mem_b(a)};
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    // junk request while busy must be ignored
    req_write = !w; req_word = !wd; req_addr = ~a; req_wdata = ~d;
    for (int c = 0; c < n; c++) begin
      int waits;
      waits = (wbase + c) % 3;
      for (int k = 0; k <= waits; k++) begin
        logic [AW-1:0] e;
        check(bus_active && !req_ready, "R10/R9 active", {62'd0, bus_active, req_ready}, 64'd2);
        check(bus_addr == ea[c], (wd && a[0]) ? "R4 addr" : "R2/R3 addr", 64'(bus_addr), 64'(ea[c]));
        check(bus_bhe_n == eb[c], "R3/R4 bhe_n", 64'(bus_bhe_n), 64'(eb[c]));
        check(bus_wr == w, "R5 wr", 64'(bus_wr), 64'(w));
        if (w) check(bus_wdata == ed[c], "R5 wdata", 64'(bus_wdata), 64'(ed[c]));
        check(!(bus_bhe_n && bus_addr[0]), "R3 reserved code", 64'(bus_addr[0]), 64'd0);
        if (k > 0) check(done == 1'b0, "R7 no early done", 64'(done), 64'd0);
        bus_ready = (k == waits);
        e = ea[c] & ~AW'(1);
        bus_rdata = {mem_b(e | AW'(1)), mem_b(e)};
        if (eb[c]) bus_rdata[15:8] = ~bus_rdata[15:8];
        if (ea[c][0]) bus_rdata[7:0] = ~bus_rdata[7:0];
        @(negedge clk);
      end
    end
    bus_ready = 0; req_valid = 0;
    check(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
    if (!w) last_read = exp_r;
    check(rdata == last_read, w ? "R8 write keeps rdata" : "R6 rdata", 64'(rdata), 64'(last_read));
    @(negedge clk);
    check(done == 1'b0 && !bus_active, "R8/R9 done low, no extra cycle", {62'd0, done, bus_active}, 64'd0);
  endtask

  initial begin
    logic [AW-1:0] addrs [12];
    addrs = '{20'h00000, 20'h00001, 20'h00002, 20'h00003, 20'h00004, 20'h00005,
              20'h00006, 20'h00007, 20'hFFFFE, 20'hFFFFF, 20'h12345, 20'hABCDE};
    repeat (2) @(negedge clk);
    check(!bus_active && bus_bhe_n && !done && req_ready, "R1 in reset",
          {60'd0, bus_active, bus_bhe_n, done, req_ready}, 64'h5);
    rst_n = 1;
    @(negedge clk);
    check(!bus_active && bus_bhe_n && !done && req_ready, "R1 after reset",
          {60'd0, bus_active, bus_bhe_n, done, req_ready}, 64'h5);
    for (int i = 0; i < 12; i++)
      for (int m = 0; m < 4; m++)
        access(m[1], m[0], addrs[i], 16'hA000 ^ 16'(addrs[i] * 13) ^ 16'(m * 16'h0F11), i + m);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule